// File: doc/BRIEF.md
# Stereo Audio Serial Clock and Sample Interrupt Generator

This block times a two-channel serial audio port. As clock master it divides the system clock by an 8-bit value to make the bit clock. It also makes the word strobe, which marks the left and right halves of a 32-bit frame. As slave it follows a bit clock and a word strobe driven from outside the chip. In both roles it shifts out a 16-bit left word and a 16-bit right word, MSB first. It raises a one-cycle sample interrupt on the events chosen by the mode inputs.

The interrupt sources are the rising strobe edge, the falling strobe edge, and the MSB slot of every word. Any mix of them may be enabled. The surrounding logic reads the strobe level and the current channel from two status outputs. Writing the divider restarts the frame at once, so software can change the sample rate without waiting for the frame to end.

Top module: `aud_serclk_gen`

## Requirements
- R1: In master mode with divider value D, `sck_out` is a square wave with a period of 2*(D+1) system clocks.
- R2: A pulse on `div_wr` loads `div_val` and restarts the frame from slot 0, with strobe low and `sck_out` low. With word-MSB interrupts enabled, the first `irq` is seen 2*(D+1) clock edges after the write edge. After reset the divider is 8, so this first `irq` comes 18 edges after the last reset edge.
- R3: With only the rising-edge source enabled and strobes on, `irq` pulses every 64*(D+1) clocks in master mode.
- R4: With the falling-edge source enabled, `irq` pulses on every falling strobe edge. With both edge sources enabled, the pulses come every 32*(D+1) clocks.
- R5: With the word-MSB source enabled, `irq` pulses in the first bit slot of each word, every 32*(D+1) clocks in master mode.
- R6: In master mode with `mode_strobe_en` low, `ws_out` stays low and the edge sources raise no `irq`.
- R7: Strobe low is the left channel. `sd_out` changes after the falling bit clock edge. The MSB of a word comes one bit slot after the strobe transition, and 16 bits per channel follow it.
- R8: `stat_ws` equals the internal strobe level. `stat_left` is high while a left-word bit is on `sd_out`.
- R9: In slave mode, `ext_sck` and `ext_ws` pass through a two-flop synchroniser. The frame advances on each falling edge of the synchronised clock, and a strobe change realigns the word. Data, interrupts and status then follow the rules of R3 to R8, while `sck_out` and `ws_out` are held low.
- R10: `irq` is a single-cycle pulse.
- R11: While reset is asserted, `sck_out`, `ws_out`, `sd_out`, `irq` and `stat_ws` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_val | input | 8 | Bit clock divider value D |
| div_wr | input | 1 | Load `div_val` and restart the frame |
| mode_master | input | 1 | 1: generate the clock internally; 0: follow the external clock |
| mode_strobe_en | input | 1 | Enable word strobe generation in master mode |
| mode_irq_rise | input | 1 | Interrupt on the rising strobe edge |
| mode_irq_fall | input | 1 | Interrupt on the falling strobe edge |
| mode_irq_word | input | 1 | Interrupt in the MSB slot of every word |
| tx_left | input | 16 | Left-channel transmit word |
| tx_right | input | 16 | Right-channel transmit word |
| ext_sck | input | 1 | External bit clock (slave mode) |
| ext_ws | input | 1 | External word strobe (slave mode) |
| sck_out | output | 1 | Generated bit clock |
| ws_out | output | 1 | Generated word strobe |
| sd_out | output | 1 | Serial transmit data |
| irq | output | 1 | Sample interrupt pulse |
| stat_ws | output | 1 | Current strobe level |
| stat_left | output | 1 | Left word currently on `sd_out` |

## Verification
The assertions assume that the mode inputs change only when a `div_wr` pulse follows them. In slave mode they also assume that the external bit clock stays in each level for several system clocks, so that the synchroniser never merges two edges. The bench applies every mode change first and then writes the divider. It drives the external clock with half-periods of eight system clocks, and it changes the external strobe only together with the falling edge of that clock. It sweeps several divider values across every single interrupt source and the two-edge combination. It rebuilds every shifted word from `sd_out`, sampled on the rising bit clock edge.

// File: rtl/aud_serclk_pkg.sv
// Shared types for the audio serial clock generator.
// Assumes: mode inputs are static between divider writes.
package aud_serclk_pkg;
    // Mode selection gathered from the top-level inputs.
    typedef struct packed {
        logic master;
        logic strobe_en;
        logic irq_rise;
        logic irq_fall;
        logic irq_word;
    } aud_mode_t;
endpackage

// File: rtl/aud_bclk_div.sv
// Bit clock divider: the half-period counter toggles sck every DIV+1 clocks.
// Gives one tick per falling sck edge. Idles low when not master.
// Assumes: div_wr is a single-cycle strobe from the register side.
module aud_bclk_div #(
    parameter int DIV_W   = 8,
    parameter int DIV_RST = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_val,
    input  logic             div_wr,
    input  logic             run,
    output logic             sck,
    output logic             fall_tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;
    logic             sck_q;
    logic             at_lim;

    assign at_lim    = (cnt_q == div_q);
    assign fall_tick = run && !div_wr && at_lim && sck_q;
    assign sck       = sck_q;

    // Divider register, half-period counter and clock phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= DIV_W'(DIV_RST);
            cnt_q <= '0;
            sck_q <= 1'b0;
        end else if (div_wr) begin
            div_q <= div_val;
            cnt_q <= '0;
            sck_q <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            sck_q <= 1'b0;
        end else if (at_lim) begin
            cnt_q <= '0;
            sck_q <= ~sck_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R1
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= div_q);
    // R1
    sck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!div_wr && run && !at_lim) |=> $stable(sck_q));
    // R2
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_wr |=> (!sck_q && cnt_q == '0));
endmodule

// File: rtl/aud_sync.sv
// Multi-flop synchroniser for asynchronous inputs. It also gives the
// sample one stage later, for edge detection.
// Assumes: inputs hold each level for longer than STAGES+1 clocks.
module aud_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);
    logic [STAGES:0][W-1:0] st;

    // Shift chain: stage 0 samples the pin, the last stage is the edge reference.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= '0;
        end else begin
            st[0] <= d;
            for (int s = 1; s <= STAGES; s++) begin
                st[s] <= st[s-1];
            end
        end
    end

    assign q      = st[STAGES-1];
    assign q_prev = st[STAGES];
endmodule

// File: rtl/aud_frame_seq.sv
// Frame sequencer: bit slot counter, word strobe, serial data and interrupt
// selection. It advances once per falling bit clock event.
// Assumes: a 32-slot frame (2*WORD_W), with WORD_W a power of two.
module aud_frame_seq
    import aud_serclk_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  aud_mode_t         mode,
    input  logic              m_tick,
    input  logic              s_tick,
    input  logic              s_ws,
    input  logic [WORD_W-1:0] left_w,
    input  logic [WORD_W-1:0] right_w,
    output logic              ws,
    output logic              sd,
    output logic              in_left,
    output logic              irq
);
    localparam int IDX_W = $clog2(WORD_W);
    localparam int BC_W  = IDX_W + 1;
    localparam logic [BC_W-1:0] HALF = {1'b1, {IDX_W{1'b0}}};

    logic [BC_W-1:0]  bc_q, bc_n, k;
    logic             ws_q, ws_n, sd_q, left_q, irq_q, tick;
    logic [IDX_W-1:0] idx;
    logic             bit_n, chan, ev;

    // Select the active tick and work out the next slot and strobe.
    always_comb begin
        tick = mode.master ? m_tick : s_tick;
        if (mode.master) begin
            bc_n = bc_q + 1'b1;
            ws_n = mode.strobe_en && bc_n[BC_W-1];
        end else begin
            bc_n = (s_ws != ws_q) ? (s_ws ? HALF : '0) : bc_q + 1'b1;
            ws_n = s_ws;
        end
        k     = bc_n - 1'b1;
        chan  = k[BC_W-1];
        idx   = IDX_W'(WORD_W - 1) - k[IDX_W-1:0];
        bit_n = chan ? right_w[idx] : left_w[idx];
        ev    = (mode.irq_rise && !ws_q && ws_n)
             || (mode.irq_fall && ws_q && !ws_n)
             || (mode.irq_word && k[IDX_W-1:0] == '0);
    end

    // Frame state registers, advanced on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            bc_q   <= '0;
            ws_q   <= 1'b0;
            sd_q   <= 1'b0;
            left_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= tick && ev;
            if (tick) begin
                bc_q   <= bc_n;
                ws_q   <= ws_n;
                sd_q   <= bit_n;
                left_q <= !chan;
            end
        end
    end

    assign ws      = ws_q;
    assign sd      = sd_q;
    assign in_left = left_q;
    assign irq     = irq_q;

    // R10
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);
    // R7
    ws_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> ($stable(ws_q) && $stable(sd_q)));
    // R2
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!ws_q && !irq_q));
endmodule

// File: rtl/aud_serclk_gen.sv
// Top level: bit clock divider, external input synchroniser and frame
// sequencer, wired for master or slave operation.
// Assumes: mode inputs change only together with a divider write.
module aud_serclk_gen
    import aud_serclk_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int DIV_RST = 8,
    parameter int WORD_W  = 16,
    parameter int SYNC_N  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_val,
    input  logic              div_wr,
    input  logic              mode_master,
    input  logic              mode_strobe_en,
    input  logic              mode_irq_rise,
    input  logic              mode_irq_fall,
    input  logic              mode_irq_word,
    input  logic [WORD_W-1:0] tx_left,
    input  logic [WORD_W-1:0] tx_right,
    input  logic              ext_sck,
    input  logic              ext_ws,
    output logic              sck_out,
    output logic              ws_out,
    output logic              sd_out,
    output logic              irq,
    output logic              stat_ws,
    output logic              stat_left
);
    aud_mode_t  mode;
    logic       m_sck, m_tick, s_tick, ws_i;
    logic [1:0] ext_q, ext_p;

    assign mode = '{master: mode_master, strobe_en: mode_strobe_en,
                    irq_rise: mode_irq_rise, irq_fall: mode_irq_fall,
                    irq_word: mode_irq_word};

    aud_bclk_div #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_div (
        .clk(clk), .rst_n(rst_n), .div_val(div_val), .div_wr(div_wr),
        .run(mode_master), .sck(m_sck), .fall_tick(m_tick)
    );

    aud_sync #(.W(2), .STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({ext_ws, ext_sck}),
        .q(ext_q), .q_prev(ext_p)
    );

    // Falling edge of the synchronised external clock, used only in slave mode.
    assign s_tick = !mode_master && !ext_q[0] && ext_p[0];

    aud_frame_seq #(.WORD_W(WORD_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .restart(div_wr), .mode(mode),
        .m_tick(m_tick), .s_tick(s_tick), .s_ws(ext_q[1]),
        .left_w(tx_left), .right_w(tx_right),
        .ws(ws_i), .sd(sd_out), .in_left(stat_left), .irq(irq)
    );

    assign sck_out = m_sck;
    assign ws_out  = mode_master && ws_i;
    assign stat_ws = ws_i;

    // R9
    slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_master && !div_wr) |=> (!sck_out && !ws_out));
endmodule

// File: tb/aud_serclk_gen_tb.sv
module aud_serclk_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  div_val = 8'd0;
    logic        div_wr = 1'b0;
    logic        m_master = 1'b1, m_se = 1'b1, m_rise = 1'b0, m_fall = 1'b0, m_word = 1'b1;
    logic [15:0] tx_left = 16'h0, tx_right = 16'h0;
    logic        ext_sck = 1'b0, ext_ws = 1'b0;
    logic        sck_out, ws_out, sd_out, irq, stat_ws, stat_left;

    int nvec = 0, nfail = 0;
    longint cyc = 0, last_irq = 0, last_rise = 0, exp_int = 0, exp_sck = 0;
    bit mon_en = 0, have_irq = 0, have_rise = 0, data_chk = 0, prev_irq = 0;
    bit p_sck = 0, p_ws = 0, o_sck, o_ws;
    int nirq = 0, nrise = 0, ws_hi = 0;
    logic [15:0] sh = '0;
    string irq_tag = "R5";

    always #2 clk = ~clk;

    aud_serclk_gen u_dut (
        .clk(clk), .rst_n(rst_n), .div_val(div_val), .div_wr(div_wr),
        .mode_master(m_master), .mode_strobe_en(m_se), .mode_irq_rise(m_rise),
        .mode_irq_fall(m_fall), .mode_irq_word(m_word),
        .tx_left(tx_left), .tx_right(tx_right), .ext_sck(ext_sck), .ext_ws(ext_ws),
        .sck_out(sck_out), .ws_out(ws_out), .sd_out(sd_out), .irq(irq),
        .stat_ws(stat_ws), .stat_left(stat_left)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: interrupt spacing, bit clock period, word rebuild and status.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (mon_en) begin
            if (irq) begin
                nirq++;
                chk(!prev_irq, "R10", 1, 0);
                if (have_irq) chk(cyc - last_irq == exp_int, irq_tag, cyc - last_irq, exp_int);
                last_irq = cyc;
                have_irq = 1;
            end
            if (ws_out) ws_hi++;
            o_sck = m_master ? sck_out : ext_sck;
            o_ws  = m_master ? ws_out : ext_ws;
            if (o_sck && !p_sck) begin
                if (m_master && have_rise) chk(cyc - last_rise == exp_sck, "R1", cyc - last_rise, exp_sck);
                last_rise = cyc;
                have_rise = 1;
                sh = {sh[14:0], sd_out};
                nrise++;
                if (o_ws != p_ws) begin
                    if (data_chk && nrise >= 17)
                        chk(sh == (p_ws ? tx_right : tx_left), m_master ? "R7" : "R9",
                            sh, p_ws ? tx_right : tx_left);
                    chk(stat_left == !p_ws, "R8", stat_left, !p_ws);
                    chk(stat_ws == o_ws, "R8", stat_ws, o_ws);
                    p_ws = o_ws;
                end
            end
            p_sck = o_sck;
        end
        prev_irq = irq;
    end

    task automatic setup(input bit ms, input [7:0] d, input bit se, input bit r,
                         input bit f, input bit w, input longint expi, input string tag);
        mon_en = 0;
        @(posedge clk); #1;
        m_master = ms; m_se = se; m_rise = r; m_fall = f; m_word = w;
        tx_left = 16'hC35A ^ {d, 8'h81}; tx_right = 16'h5AC3 + {8'h0, d} * 16'h0107;
        div_val = d; div_wr = 1'b1; ext_sck = 1'b0; ext_ws = 1'b0;
        @(posedge clk); #1;
        div_wr = 1'b0;
        have_irq = 0; have_rise = 0; nirq = 0; nrise = 0; ws_hi = 0;
        p_sck = 0; p_ws = 0; sh = '0;
        exp_int = expi; exp_sck = 2 * (longint'(d) + 1); irq_tag = tag; data_chk = 1;
        mon_en = 1;
    endtask

    task automatic run_m(input [7:0] d, input bit se, input bit r, input bit f,
                         input bit w, input longint expi, input string tag);
        longint len = 4 * 64 * (longint'(d) + 1);
        longint n_exp;
        setup(1'b1, d, se, r, f, w, expi, tag);
        repeat (len) @(posedge clk);
        #1 mon_en = 0;
        n_exp = len / expi;
        chk(nirq >= n_exp - 1 && nirq <= n_exp, tag, nirq, n_exp);
    endtask

    task automatic run_s(input bit r, input bit f, input bit w, input longint expi);
        int bitcnt = 0;
        setup(1'b0, 8'd3, 1'b1, r, f, w, expi, "R9");
        for (int b = 0; b < 4 * 32; b++) begin
            ext_sck = 1'b1;
            repeat (8) @(posedge clk);
            #1;
            bitcnt = (bitcnt + 1) % 32;
            ext_sck = 1'b0;
            ext_ws = (bitcnt >= 16);
            repeat (8) @(posedge clk);
            #1;
        end
        mon_en = 0;
        chk(nirq >= (4 * 512) / expi - 1, "R9", nirq, (4 * 512) / expi);
        chk(sck_out == 1'b0 && ws_out == 1'b0, "R9", {sck_out, ws_out}, 0);
    endtask

    task automatic first_irq(input int exp, input string tag);
        int k = 0;
        for (int i = 0; i < 2000; i++) begin
            @(posedge clk);
            k++;
            @(negedge clk);
            if (irq) break;
        end
        chk(k == exp, tag, k, exp);
    endtask

    initial begin
        int d_list[5] = '{0, 1, 2, 3, 6};
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        chk(sck_out == 0, "R11", sck_out, 0);
        chk(ws_out == 0, "R11", ws_out, 0);
        chk(sd_out == 0, "R11", sd_out, 0);
        chk(irq == 0, "R11", irq, 0);
        chk(stat_ws == 0, "R11", stat_ws, 0);
        // R2: reset divider value 8 gives first word interrupt 18 edges later
        @(posedge clk); #1 rst_n = 1'b1;
        first_irq(18, "R2");
        // R2: divider write restarts timing
        @(posedge clk); #1 div_val = 8'd4; div_wr = 1'b1;
        @(posedge clk); #1 div_wr = 1'b0;
        first_irq(10, "R2");
        for (int i = 0; i < 5; i++) begin
            run_m(8'(d_list[i]), 1, 1, 0, 0, 64 * (d_list[i] + 1), "R3");
            run_m(8'(d_list[i]), 1, 0, 1, 0, 64 * (d_list[i] + 1), "R4");
            run_m(8'(d_list[i]), 1, 1, 1, 0, 32 * (d_list[i] + 1), "R4");
            run_m(8'(d_list[i]), 1, 0, 0, 1, 32 * (d_list[i] + 1), "R5");
        end
        // R6: strobes disabled, edge sources enabled: no strobe, no interrupt
        setup(1'b1, 8'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1, "R6");
        repeat (4 * 192) @(posedge clk);
        #1 mon_en = 0;
        chk(nirq == 0, "R6", nirq, 0);
        chk(ws_hi == 0, "R6", ws_hi, 0);
        // R9 slave mode across the interrupt sources
        run_s(1, 0, 0, 512);
        run_s(1, 1, 0, 256);
        run_s(0, 0, 1, 256);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        nvec++;
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule